// File: doc/BRIEF.md
# Corrected Min-Sum Check Node Unit

This block is the check-node half of an iterative LDPC decoder's message-passing engine. It serves one parity check at a time. The variable-to-check messages for that check arrive one edge per cycle in sign-magnitude form. Once the edge marked as last has been taken in, the block sends back one check-to-variable message per edge, in the order the edges arrived.

The update uses only comparisons, additions, subtractions and shifts. While the edges stream in, the unit tracks the two smallest magnitudes, where the smallest one sits, and the parity of all signs. Each outgoing message is then built from that summary. A run-time selector, captured with the last edge of each check, picks one of two ways to shrink the optimistic min-sum magnitude. One is a scaling built from two power-of-two shift terms, 0.75 by default. The other is a fixed offset subtraction that saturates at zero. Message width, maximum check degree, offset and shift amounts are parameters.

Top module: `msCheckNode`

## Requirements
- R1: After reset, `outValid` is 0 and `inReady` is 1.
- R2: While a check is being collected, one edge is accepted on each cycle that `inValid` and `inReady` are both high. `outValid` stays 0 until the edge carrying `inLast` = 1 has been accepted, and it is 1 on the cycle right after that edge. `inReady` is 0 for as long as messages are being sent.
- R3: Before correction, the magnitude sent to edge j is the smallest input magnitude among all other edges of the check. A check with a single edge sends the all-ones magnitude (2^MAG_W - 1) before correction.
- R4: When two or more edges share the smallest magnitude, every edge of the check receives that shared value before correction.
- R5: The sign sent to edge j is the XOR of the input signs of all edges other than j. Sign bit 1 means negative.
- R6: With `corrMode` = 0 (normalized), the output magnitude is (m >> NORM_SH_A) + (m >> NORM_SH_B), where m is the magnitude from R3. The defaults 1 and 2 give a scale of 0.75.
- R7: With `corrMode` = 1 (offset), the output magnitude is m - OFFSET when m > OFFSET and 0 otherwise.
- R8: The correction mode used for a whole check is the value `corrMode` had on the cycle its last edge was accepted. Values of `corrMode` on earlier edges, or during sending, have no effect.
- R9: Exactly one output message is sent per accepted edge, in input order. `outLast` is 1 only on the final message. After that message is taken, `outValid` drops to 0 and `inReady` returns to 1.
- R10: While `outValid` is 1 and `outReady` is 0, `outSign`, `outMag` and `outLast` hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Incoming edge message is valid |
| inReady | output | 1 | Unit can accept an edge message |
| inSign | input | 1 | Sign of the incoming message (1 = negative) |
| inMag | input | MAG_W | Magnitude of the incoming message |
| inLast | input | 1 | Marks the final edge of the current check |
| corrMode | input | 1 | Correction select, sampled with the last edge: 0 shift scaling, 1 offset |
| outValid | output | 1 | Outgoing check-to-variable message is valid |
| outReady | input | 1 | Consumer takes the outgoing message |
| outSign | output | 1 | Sign of the outgoing message |
| outMag | output | MAG_W | Corrected magnitude of the outgoing message |
| outLast | output | 1 | Marks the final outgoing message of the check |

## Verification
The assertions assume that no check has more than MAX_DEG edges. A longer stream would be closed early by the controller, and the edges after that point would then be split into a second check. They also assume the consumer never sees data outside the valid window. The stimulus keeps check degrees between 1 and MAX_DEG and always sets `inLast` on the final edge. It drives `outReady` randomly, including long stalls, so that the hold rule is exercised without ever breaking the degree limit.

// File: rtl/cnuPkg.sv
package cnuPkg;

  typedef enum logic {
    CORR_NORM   = 1'b0,
    CORR_OFFSET = 1'b1
  } corrSel_e;

  // strobes from the controller to the datapath
  typedef struct packed {
    logic absorb;   // an edge is taken this cycle
    logic first;    // it is the first edge of a check
    logic close;    // it is the final edge of a check
  } cnuStrobe_t;

  typedef enum logic {
    ST_COLLECT = 1'b0,
    ST_EMIT    = 1'b1
  } cnuState_e;

endpackage

// File: rtl/cnuCorrect.sv
module cnuCorrect
  import cnuPkg::*;
#(
  parameter int MAG_W     = 5,
  parameter int OFFSET    = 2,
  parameter int NORM_SH_A = 1,
  parameter int NORM_SH_B = 2
) (
  input  logic             modeSel,
  input  logic [MAG_W-1:0] magIn,
  output logic [MAG_W-1:0] magOut
);

  localparam logic [MAG_W-1:0] OFF_V = MAG_W'(OFFSET);

  logic [MAG_W-1:0] normMag;
  logic [MAG_W-1:0] offMag;

  generate
    if (NORM_SH_B == 0) begin : gSingleTerm
      assign normMag = magIn >> NORM_SH_A;
    end else begin : gTwoTerms
      assign normMag = (magIn >> NORM_SH_A) + (magIn >> NORM_SH_B);
    end
  endgenerate

  always_comb begin
    if (magIn > OFF_V) offMag = magIn - OFF_V;
    else               offMag = '0;
  end

  assign magOut = (modeSel == CORR_OFFSET) ? offMag : normMag;

endmodule

// File: rtl/cnuCtrl.sv
module cnuCtrl
  import cnuPkg::*;
#(
  parameter int MAX_DEG = 16,
  parameter int IDX_W   = $clog2(MAX_DEG)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic             inLast,
  output logic             inReady,
  output logic             outValid,
  input  logic             outReady,
  output logic             outLast,
  output cnuStrobe_t       strobe,
  output logic [IDX_W-1:0] inIdx,
  output logic [IDX_W-1:0] outIdx
);

  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(MAX_DEG - 1);

  cnuState_e        state;
  logic [IDX_W-1:0] edgeCnt;
  logic [IDX_W-1:0] lastIdx;
  logic [IDX_W-1:0] emitIdx;
  logic             accept;
  logic             closeNow;

  assign inReady  = (state == ST_COLLECT);
  assign outValid = (state == ST_EMIT);
  assign outLast  = outValid && (emitIdx == lastIdx);
  assign accept   = inValid && inReady;
  assign closeNow = accept && (inLast || edgeCnt == TOP_IDX);

  assign strobe.absorb = accept;
  assign strobe.first  = accept && (edgeCnt == '0);
  assign strobe.close  = closeNow;
  assign inIdx  = edgeCnt;
  assign outIdx = emitIdx;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_COLLECT;
      edgeCnt <= '0;
      lastIdx <= '0;
      emitIdx <= '0;
    end else begin
      case (state)
        ST_COLLECT: begin
          if (closeNow) begin
            lastIdx <= edgeCnt;
            edgeCnt <= '0;
            emitIdx <= '0;
            state   <= ST_EMIT;
          end else if (accept) begin
            edgeCnt <= edgeCnt + 1'b1;
          end
        end
        ST_EMIT: begin
          if (outReady) begin
            if (emitIdx == lastIdx) state <= ST_COLLECT;
            else                    emitIdx <= emitIdx + 1'b1;
          end
        end
        default: state <= ST_COLLECT;
      endcase
    end
  end

endmodule

// File: rtl/cnuDatapath.sv
module cnuDatapath
  import cnuPkg::*;
#(
  parameter int MAG_W     = 5,
  parameter int MAX_DEG   = 16,
  parameter int IDX_W     = $clog2(MAX_DEG),
  parameter int OFFSET    = 2,
  parameter int NORM_SH_A = 1,
  parameter int NORM_SH_B = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  cnuStrobe_t       strobe,
  input  logic [IDX_W-1:0] inIdx,
  input  logic [IDX_W-1:0] outIdx,
  input  logic             inSign,
  input  logic [MAG_W-1:0] inMag,
  input  logic             corrMode,
  output logic             outSign,
  output logic [MAG_W-1:0] outMag,
  output logic [MAG_W-1:0] minLo,
  output logic [MAG_W-1:0] minHi
);

  localparam logic [MAG_W-1:0] MAG_MAX = '1;

  logic [MAG_W-1:0]   min1;
  logic [MAG_W-1:0]   min2;
  logic [IDX_W-1:0]   minPos;
  logic               sgnAll;
  logic [MAX_DEG-1:0] edgeSign;
  logic               modeReg;
  logic [MAG_W-1:0]   rawMag;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      min1     <= MAG_MAX;
      min2     <= MAG_MAX;
      minPos   <= '0;
      sgnAll   <= 1'b0;
      edgeSign <= '0;
      modeReg  <= CORR_NORM;
    end else if (strobe.absorb) begin
      edgeSign[inIdx] <= inSign;
      if (strobe.first) begin
        min1   <= inMag;
        min2   <= MAG_MAX;
        minPos <= inIdx;
        sgnAll <= inSign;
      end else begin
        sgnAll <= sgnAll ^ inSign;
        if (inMag < min1) begin
          min2   <= min1;
          min1   <= inMag;
          minPos <= inIdx;
        end else if (inMag < min2) begin
          min2 <= inMag;
        end
      end
      if (strobe.close) modeReg <= corrMode;
    end
  end

  assign rawMag  = (outIdx == minPos) ? min2 : min1;
  assign outSign = sgnAll ^ edgeSign[outIdx];
  assign minLo   = min1;
  assign minHi   = min2;

  cnuCorrect #(
    .MAG_W    (MAG_W),
    .OFFSET   (OFFSET),
    .NORM_SH_A(NORM_SH_A),
    .NORM_SH_B(NORM_SH_B)
  ) uCorr (
    .modeSel(modeReg),
    .magIn  (rawMag),
    .magOut (outMag)
  );

endmodule

// File: rtl/msCheckNode.sv
module msCheckNode
  import cnuPkg::*;
#(
  parameter int MAG_W     = 5,
  parameter int MAX_DEG   = 16,
  parameter int OFFSET    = 2,
  parameter int NORM_SH_A = 1,
  parameter int NORM_SH_B = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  output logic             inReady,
  input  logic             inSign,
  input  logic [MAG_W-1:0] inMag,
  input  logic             inLast,
  input  logic             corrMode,
  output logic             outValid,
  input  logic             outReady,
  output logic             outSign,
  output logic [MAG_W-1:0] outMag,
  output logic             outLast
);

  localparam int IDX_W = (MAX_DEG > 1) ? $clog2(MAX_DEG) : 1;

  cnuStrobe_t       strobe;
  logic [IDX_W-1:0] inIdx;
  logic [IDX_W-1:0] outIdx;
  logic [MAG_W-1:0] minLo;
  logic [MAG_W-1:0] minHi;

  cnuCtrl #(
    .MAX_DEG(MAX_DEG),
    .IDX_W  (IDX_W)
  ) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .inLast  (inLast),
    .inReady (inReady),
    .outValid(outValid),
    .outReady(outReady),
    .outLast (outLast),
    .strobe  (strobe),
    .inIdx   (inIdx),
    .outIdx  (outIdx)
  );

  cnuDatapath #(
    .MAG_W    (MAG_W),
    .MAX_DEG  (MAX_DEG),
    .IDX_W    (IDX_W),
    .OFFSET   (OFFSET),
    .NORM_SH_A(NORM_SH_A),
    .NORM_SH_B(NORM_SH_B)
  ) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .inIdx   (inIdx),
    .outIdx  (outIdx),
    .inSign  (inSign),
    .inMag   (inMag),
    .corrMode(corrMode),
    .outSign (outSign),
    .outMag  (outMag),
    .minLo   (minLo),
    .minHi   (minHi)
  );

endmodule

// File: rtl/cnuChecker.sv
module cnuChecker #(
  parameter int MAG_W = 5
) (
  input logic             clk,
  input logic             rstN,
  input logic             inValid,
  input logic             inReady,
  input logic             inLast,
  input logic             outValid,
  input logic             outReady,
  input logic             outSign,
  input logic [MAG_W-1:0] outMag,
  input logic             outLast,
  input logic [MAG_W-1:0] minLo,
  input logic [MAG_W-1:0] minHi
);

  // R2: input side is closed while messages go out
  a_r2_in_blocked: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> !inReady);

  // R2: sending begins only right after a last edge was taken
  a_r2_out_after_last: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outValid) |-> $past(inValid && inReady && inLast));

  // R3: running minimum never exceeds the runner-up
  a_r3_min_order: assert property (@(posedge clk) disable iff (!rstN)
    minLo <= minHi);

  // R9: taking the final message ends the output burst
  a_r9_last_closes: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outReady && outLast) |=> (!outValid && inReady));

  // R10: a stalled message holds steady
  a_r10_hold: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outMag) &&
                                 $stable(outSign) && $stable(outLast)));

endmodule

bind msCheckNode cnuChecker #(.MAG_W(MAG_W)) uChk (
  .clk     (clk),
  .rstN    (rstN),
  .inValid (inValid),
  .inReady (inReady),
  .inLast  (inLast),
  .outValid(outValid),
  .outReady(outReady),
  .outSign (outSign),
  .outMag  (outMag),
  .outLast (outLast),
  .minLo   (minLo),
  .minHi   (minHi)
);

// File: tb/sim_msCheckNode.sv
module sim_msCheckNode;

  localparam int MAG_W   = 5;
  localparam int MAX_DEG = 16;
  localparam int OFFSET  = 2;
  localparam int SH_A    = 1;
  localparam int SH_B    = 2;
  localparam int MAGMAX  = (1 << MAG_W) - 1;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             inValid = 1'b0;
  logic             inReady;
  logic             inSign = 1'b0;
  logic [MAG_W-1:0] inMag = '0;
  logic             inLast = 1'b0;
  logic             corrMode = 1'b0;
  logic             outValid;
  logic             outReady = 1'b0;
  logic             outSign;
  logic [MAG_W-1:0] outMag;
  logic             outLast;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int mags [MAX_DEG];
  bit sgns [MAX_DEG];

  always #5 clk = ~clk;
  always @(posedge clk) cyc++;

  msCheckNode #(
    .MAG_W(MAG_W), .MAX_DEG(MAX_DEG), .OFFSET(OFFSET),
    .NORM_SH_A(SH_A), .NORM_SH_B(SH_B)
  ) u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inSign(inSign), .inMag(inMag), .inLast(inLast), .corrMode(corrMode),
    .outValid(outValid), .outReady(outReady), .outSign(outSign),
    .outMag(outMag), .outLast(outLast)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  function automatic int rawOther(input int j, input int deg);
    int m = MAGMAX;
    for (int i = 0; i < deg; i++) if (i != j && mags[i] < m) m = mags[i];
    return m;
  endfunction

  function automatic bit signOther(input int j, input int deg);
    bit s = 1'b0;
    for (int i = 0; i < deg; i++) if (i != j) s ^= sgns[i];
    return s;
  endfunction

  function automatic int corrected(input int m, input bit mode);
    if (mode) return (m > OFFSET) ? m - OFFSET : 0;
    return (m >> SH_A) + (m >> SH_B);
  endfunction

  // sends one check, then drains it with random backpressure
  task automatic runCheck(input int deg, input bit mode, input string tag);
    int k = 0;
    bit stalled = 1'b0;
    int snapMag = 0;
    bit snapSign = 1'b0;
    for (int i = 0; i < deg; i++) begin
      @(negedge clk);
      check(outValid == 1'b0, "R2 no early output", int'(outValid), 0);
      inValid  = 1'b1;
      inMag    = MAG_W'(mags[i]);
      inSign   = sgns[i];
      inLast   = (i == deg - 1);
      corrMode = (i == deg - 1) ? mode : 1'($urandom);  // R8
    end
    @(negedge clk);
    inValid  = 1'b0;
    inLast   = 1'b0;
    corrMode = ~mode;  // R8: changing it now must not matter
    check(outValid == 1'b1 && inReady == 1'b0, "R2 output after last",
          {outValid, inReady}, 2);
    while (k < deg) begin
      if (stalled) begin
        check(outValid && int'(outMag) == snapMag && outSign == snapSign,
              "R10 hold while stalled", int'(outMag), snapMag);
      end
      outReady = ($urandom % 3) != 0;
      if (outValid && outReady) begin
        check(int'(outMag) == corrected(rawOther(k, deg), mode),
              {tag, " R3/R6/R7/R8 magnitude"}, int'(outMag),
              corrected(rawOther(k, deg), mode));
        check(outSign == signOther(k, deg), {tag, " R5 sign"},
              int'(outSign), int'(signOther(k, deg)));
        check(outLast == (k == deg - 1), {tag, " R9 last flag"},
              int'(outLast), int'(k == deg - 1));
        k++;
        stalled = 1'b0;
      end else begin
        stalled  = outValid;
        snapMag  = int'(outMag);
        snapSign = outSign;
      end
      @(negedge clk);
    end
    outReady = 1'b0;
    check(outValid == 1'b0 && inReady == 1'b1, "R9 back to collect",
          {outValid, inReady}, 1);
  endtask

  initial begin
    void'($urandom(32'd20250607));
    repeat (3) @(negedge clk);
    check(outValid == 1'b0 && inReady == 1'b1, "R1 reset state",
          {outValid, inReady}, 1);
    rstN = 1'b1;
    @(negedge clk);
    check(outValid == 1'b0 && inReady == 1'b1, "R1 after release",
          {outValid, inReady}, 1);

    // R3 single edge gets all-ones before correction
    mags[0] = 9; sgns[0] = 1'b1;
    runCheck(1, 1'b0, "R3 single norm");
    runCheck(1, 1'b1, "R3 single offset");

    // R4 tie for the minimum
    mags[0] = 5; mags[1] = 3; mags[2] = 3; mags[3] = 7;
    sgns[0] = 1; sgns[1] = 0; sgns[2] = 1; sgns[3] = 1;
    runCheck(4, 1'b0, "R4 tie norm");
    runCheck(4, 1'b1, "R4 tie offset");

    // R7 offset saturation at zero
    mags[0] = 0; mags[1] = 1; mags[2] = 4;
    sgns[0] = 0; sgns[1] = 1; sgns[2] = 0;
    runCheck(3, 1'b1, "R7 saturate");

    // R6 full-scale magnitudes, full degree
    for (int i = 0; i < MAX_DEG; i++) begin
      mags[i] = MAGMAX; sgns[i] = 1'b1;
    end
    mags[MAX_DEG-1] = 30;
    runCheck(MAX_DEG, 1'b0, "R6 full degree");

    // random checks, both modes
    for (int t = 0; t < 60; t++) begin
      int deg = 1 + int'($urandom % MAX_DEG);
      for (int i = 0; i < deg; i++) begin
        mags[i] = int'($urandom % (MAGMAX + 1));
        sgns[i] = 1'($urandom);
      end
      runCheck(deg, 1'($urandom), "rand");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule